// File: doc/BRIEF.md
# Serial DAC Write-Frame Front End

This block is the digital front end of a 16-bit voltage-output converter. A host writes to it over a three-wire link: an active-low frame select, a serial clock and a serial data line. The three inputs are brought into the system clock domain through synchronizer chains. Falling edges of the serial clock are detected there, and the data bit is taken at each such edge while the frame select is low. Once 24 bits have arrived, the block decodes them into a 16-bit converter code and a 2-bit power-down mode. Both land in the output registers on the same clock, and a one-cycle load strobe marks that clock.

A frame that the host ends early by raising the frame select is thrown away, and the stored code and mode stay as they were. A word of 24 ones is a software reset. It puts the block back in its power-on state: code at midscale (0x8000) and the mode set to run. Three separate enables are derived from the mode to drive the output termination: high impedance, a 100 kΩ pulldown and a 1 kΩ pulldown.

The serial link has no back-pressure. The host sets the pace, and the block accepts every bit that arrives in a frame. The load strobe is a plain status pulse that carries no handshake. The system clock must run at least four times as fast as the serial clock.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the code output is 0x8000, the mode output is 00, all three termination enables are low and the load strobe is low.
- R2: Bits are taken on falling serial-clock edges while the frame select is low, most significant bit first. Frame bit positions 15..0 carry the code and positions 17..16 carry the mode.
- R3: The code and mode change together on the fourth rising system-clock edge after the 24th serial-clock fall is presented at the inputs. The load strobe is high for exactly that one cycle, and the outputs do not change at any other time.
- R4: If the frame select rises before the 24th fall, the frame is discarded. Code and mode stay unchanged, no strobe is produced, and the next frame starts from an empty shift register.
- R5: The mode encoding is as follows. 00 is run with all enables low. 01 raises only the high-impedance enable. 10 raises only the 100 kΩ enable. 11 raises only the 1 kΩ enable. At most one enable is ever high.
- R6: A complete frame of 24 ones loads code 0x8000 and mode 00, and it produces a load strobe.
- R7: After the 24th fall, further serial-clock falls have no effect until the frame select rises.
- R8: In a frame that is not all ones, bits 23..18 are ignored. The code and mode come only from bits 15..0 and 17..16.
- R9: Serial-clock falls while the frame select is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| sync_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 16 | Converter code register |
| pd_mode_o | output | 2 | Power-down mode (00 run, 01 high-Z, 10 100 kΩ, 11 1 kΩ) |
| hiz_en_o | output | 1 | Output high-impedance enable |
| pd100k_en_o | output | 1 | 100 kΩ pulldown enable |
| pd1k_en_o | output | 1 | 1 kΩ pulldown enable |
| load_stb_o | output | 1 | One-cycle pulse when code and mode are loaded |

## Verification
The bench builds the block with its default parameters: a 16-bit code, six pad bits and two synchronizer stages. With these values the latency from a serial edge to the outputs is four system clocks, and the bench model predicts it cycle by cycle. The defaults also make every abort length from 1 to 23 bits reachable, as well as a 23-ones abort that must not be taken for a software reset. A behavioural model tracks the expected code, mode and strobe and compares them on every clock. This covers early aborts, extra clocks after a full frame, clocks while the frame select is high, non-zero pad bits and the all-ones reset word.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_PD100K = 2'b10,
    MODE_PD1K   = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic sync_n_i,
  output logic sclk_fall,
  output logic sdi_s,
  output logic frame_act
);
  // index 0 sclk, 1 sdi, 2 frame select (idles high)
  localparam logic [2:0] RST_VAL = 3'b100;
  localparam int NSIG = 3;

  logic [NSIG-1:0]   raw;
  logic [STAGES-1:0] chain [NSIG];
  logic              sclk_prev;

  assign raw = {sync_n_i, sdi_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {STAGES{RST_VAL[g]}};
      else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= chain[0][STAGES-1];
  end

  assign sclk_fall = sclk_prev & ~chain[0][STAGES-1];
  assign sdi_s     = chain[1][STAGES-1];
  assign frame_act = ~chain[2][STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_act,
  input  logic               sclk_fall,
  input  logic               sdi_s,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_done
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!frame_act) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sclk_fall && (bit_cnt < LAST)) begin
        shreg   <= {shreg[FRAME_W-2:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST - 1'b1) frame_done <= 1'b1;
      end
    end
  end

  assign frame_word = shreg;

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);

  // R3
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_cnt == LAST));

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> (bit_cnt == '0) && !frame_done);
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [DATA_W-1:0]  code_q,
  output pd_mode_e           mode_q,
  output logic               load_q
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic sw_reset;
  assign sw_reset = &frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      mode_q <= MODE_RUN;
      load_q <= 1'b0;
    end else begin
      load_q <= frame_done;
      if (frame_done) begin
        if (sw_reset) begin
          code_q <= MID_CODE;
          mode_q <= MODE_RUN;
        end else begin
          code_q <= frame_word[DATA_W-1:0];
          mode_q <= pd_mode_e'(frame_word[DATA_W+1:DATA_W]);
        end
      end
    end
  end

  // R3
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> $stable(code_q) && $stable(mode_q));
endmodule

// File: rtl/dacfe_term.sv
module dacfe_term
  import dacfe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pd_mode_e mode,
  output logic     hiz_en,
  output logic     pd100k_en,
  output logic     pd1k_en
);
  always_comb begin
    hiz_en    = 1'b0;
    pd100k_en = 1'b0;
    pd1k_en   = 1'b0;
    case (mode)
      MODE_HIZ:    hiz_en    = 1'b1;
      MODE_PD100K: pd100k_en = 1'b1;
      MODE_PD1K:   pd1k_en   = 1'b1;
      default:     ;
    endcase
  end

  // R5
  term_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hiz_en, pd100k_en, pd1k_en}));
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PAD_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [1:0]        pd_mode_o,
  output logic              hiz_en_o,
  output logic              pd100k_en_o,
  output logic              pd1k_en_o,
  output logic              load_stb_o
);
  localparam int FRAME_W = PAD_W + 2 + DATA_W;

  logic               sclk_fall, sdi_s, frame_act, frame_done;
  logic [FRAME_W-1:0] frame_word;
  pd_mode_e           mode_q;

  dacfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sync_n_i(sync_n_i), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .frame_act(frame_act));

  dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .frame_word(frame_word), .frame_done(frame_done));

  dacfe_regs #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .frame_word(frame_word), .code_q(dac_code_o), .mode_q(mode_q),
    .load_q(load_stb_o));

  dacfe_term u_term (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .hiz_en(hiz_en_o),
    .pd100k_en(pd100k_en_o), .pd1k_en(pd1k_en_o));

  assign pd_mode_o = mode_q;

  // R5
  run_no_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode_o == 2'b00) |-> !(hiz_en_o || pd100k_en_o || pd1k_en_o));

  // R9
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !frame_done);
endmodule

// File: tb/test_serial_dac_frontend.sv
module test_serial_dac_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 2;
  localparam int LATENCY    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] code;
  logic [1:0]  mode;
  logic hiz, p100, p1k, stb;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit mon_on = 0;
  int pend = 0;
  logic [15:0] exp_code = 16'h8000, pend_code;
  logic [1:0]  exp_mode = 2'b00, pend_mode;
  logic        exp_stb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_dac_frontend i_serial_dac_frontend (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk),
    .sdi_i(sdi), .dac_code_o(code), .pd_mode_o(mode), .hiz_en_o(hiz),
    .pd100k_en_o(p100), .pd1k_en_o(p1k), .load_stb_o(stb));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // reference model: cycle-by-cycle expected outputs
  always begin
    @(negedge clk);
    #1;
    if (mon_on) begin
      exp_stb = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          exp_code = pend_code;
          exp_mode = pend_mode;
          exp_stb  = 1'b1;
        end
      end
      chk(cur_req, "code", {16'h0, code}, {16'h0, exp_code});
      chk(cur_req, "mode", {30'h0, mode}, {30'h0, exp_mode});
      chk(cur_req, "strobe", {31'h0, stb}, {31'h0, exp_stb});
      chk("R5", "enables", {29'h0, hiz, p100, p1k},
          {29'h0, exp_mode == 2'b01, exp_mode == 2'b10, exp_mode == 2'b11});
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_frame(logic [23:0] w);
    if (&w) begin
      pend_code = 16'h8000;
      pend_mode = 2'b00;
    end else begin
      pend_code = w[15:0];
      pend_mode = w[17:16];
    end
    pend = LATENCY;
  endtask

  // sends nbits of w (MSB first); leaves frame select low
  task automatic send_bits(logic [23:0] w, int nbits);
    @(negedge clk);
    sync_n = 1'b0;
    wait_clk(2);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 24) ? w[23-i] : 1'b1;
      sclk = 1'b1;
      wait_clk(HALF_SCLK);
      sclk = 1'b0;
      if (i == 23) model_frame(w);
      wait_clk(HALF_SCLK);
    end
  endtask

  task automatic end_frame();
    sync_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic write(logic [23:0] w);
    send_bits(w, 24);
    end_frame();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    #1;
    // R1 reset state
    chk("R1", "reset code", {16'h0, code}, 32'h8000);
    chk("R1", "reset mode", {30'h0, mode}, 32'h0);
    chk("R1", "reset enables", {29'h0, hiz, p100, p1k}, 32'h0);
    chk("R1", "reset strobe", {31'h0, stb}, 32'h0);
    mon_on = 1;

    cur_req = "R2";
    write(24'h001234);
    chk("R2", "code after write", {16'h0, code}, 32'h1234);
    cur_req = "R3";
    write(24'h00ABCD);
    chk("R3", "code after write", {16'h0, code}, 32'hABCD);

    cur_req = "R5";
    write(24'h015A5A);
    chk("R5", "hiz enable", {31'h0, hiz}, 32'h1);
    write(24'h02A5A5);
    chk("R5", "100k enable", {31'h0, p100}, 32'h1);
    write(24'h03FFFE);
    chk("R5", "1k enable", {31'h0, p1k}, 32'h1);
    write(24'h000001);
    chk("R5", "run mode", {30'h0, mode}, 32'h0);

    cur_req = "R8";
    write(24'hFD1357);
    chk("R8", "pad bits ignored code", {16'h0, code}, 32'h1357);
    chk("R8", "pad bits ignored mode", {30'h0, mode}, 32'h1);

    cur_req = "R6";
    write(24'hFFFFFF);
    chk("R6", "software reset code", {16'h0, code}, 32'h8000);
    chk("R6", "software reset mode", {30'h0, mode}, 32'h0);

    write(24'h02C0DE);
    cur_req = "R4";
    for (int len = 1; len < 24; len++) begin
      send_bits(24'h01F00D ^ {len[7:0], 16'h0}, len);
      end_frame();
      chk("R4", "abort keeps code", {16'h0, code}, 32'hC0DE);
    end
    send_bits(24'hFFFFFF, 23);
    end_frame();
    chk("R4", "23-ones abort is no reset", {16'h0, code}, 32'hC0DE);
    write(24'h004321);
    chk("R4", "fresh frame after aborts", {16'h0, code}, 32'h4321);

    cur_req = "R7";
    send_bits(24'h020F0F, 28);
    end_frame();
    chk("R7", "extra clocks ignored", {16'h0, code}, 32'h0F0F);
    chk("R7", "extra clocks mode", {30'h0, mode}, 32'h2);

    cur_req = "R9";
    for (int k = 0; k < 30; k++) begin
      sdi = k[0];
      sclk = 1'b1;
      wait_clk(HALF_SCLK);
      sclk = 1'b0;
      wait_clk(HALF_SCLK);
    end
    wait_clk(6);
    chk("R9", "clocks with select high", {16'h0, code}, 32'h0F0F);

    summary();
    $finish;
  end
endmodule